// File: doc/BRIEF.md
# Four-Channel Match Timer

This block is a memory-mapped timer with four independent 32-bit counters. One prescaler divides the clock and produces a common tick, and each enabled counter steps once per tick. Each counter can count up or down. Each counter compares its next value against its own match register. A match always raises a flag. Per channel, the match can also clear the counter, stop it, or both. A counter that rolls past either end of its range does so silently.

Software reaches every register through a group of four word offsets. The lowest offset writes the register directly. The other three set, clear or toggle the bits written, so a driver can change one field without a read-modify-write. A single interrupt line combines every flag whose interrupt enable is set. Typical uses are a one-shot event timer (reset and stop on match) and a free-running periodic or timestamp counter (no match action).

Top module: `quad_match_timer`

## Requirements
- R1: Bits 3:2 of the address pick the write kind. 0 replaces the register, 1 ORs the data in, 2 clears the bits set in the data, and 3 XORs the data in. A read at any of the four offsets returns the register value.
- R2: Bits 11:4 of the address select the register: 0x00 flags, 0x01 control, 0x02 direction, 0x03 to 0x06 counters 0 to 3, 0x07 prescale value, 0x08 prescale counter, 0x09 match control, 0x0A to 0x0D match registers 0 to 3. The counters and the prescale counter are read-only, so writes to them are ignored. Any other index reads zero.
- R3: Control bits 3:0 enable counters 3..0 and control bits 7:4 reset them. While a reset bit is set, its counter and the shared prescale counter are zero from the next clock edge on, and no tick is produced.
- R4: With prescale value P, the prescale counter runs 0..P while any counter is enabled. It wraps to 0 with one tick, so an enabled counter advances once every P+1 clocks. With no counter enabled, it holds.
- R5: Direction bit 4n selects count down (1) or up (0) for counter n. Wrapping between 0xFFFFFFFF and 0 sets no flag.
- R6: A match on counter n occurs on a tick where the counter's next value equals match register n. It sets flag bit n. If match-control bit 3n+1 is set, the counter loads 0 instead of the next value.
- R7: If match-control bit 3n+2 is set, a match on counter n clears control enable bit n on the same edge. This takes priority over a bus write in that cycle.
- R8: Writing 1 to a flag bit at the replace offset or the clear offset clears it. The set offset sets the bit and the toggle offset inverts it. A match in the same cycle wins over a clear.
- R9: `irq` is high exactly when some flag bit n is set together with match-control bit 3n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 12 | Byte address of the register access |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq | output | 1 | Interrupt request |

## Verification
The embedded properties assume that the address, the write data and the write strobe are known whenever a clock edge occurs. They also assume that each write lasts exactly one cycle, so one write maps to one register update. The bench sets all bus inputs together at the falling edge and drops the strobe right after the rising edge that takes the write. It samples the read data a fixed number of rising edges after each write. Every counter expectation is counted from the edge where the control write lands. The directed sequences reach the one-shot case and the periodic case. They also cover a prescaled rate, a down-count through zero, and a held channel reset.

// File: rtl/qmt_pkg.sv
package qmt_pkg;
  localparam int DATA_W = 32;

  typedef enum logic [1:0] {
    WR_PLAIN = 2'd0,
    WR_SET   = 2'd1,
    WR_CLR   = 2'd2,
    WR_TOG   = 2'd3
  } wr_kind_e;

  localparam int IDX_FLAG = 'h00;
  localparam int IDX_CTRL = 'h01;
  localparam int IDX_DIR  = 'h02;
  localparam int IDX_CNT0 = 'h03;
  localparam int IDX_PSV  = 'h07;
  localparam int IDX_PSC  = 'h08;
  localparam int IDX_MCTL = 'h09;
  localparam int IDX_MR0  = 'h0A;

  function automatic logic [DATA_W-1:0] apply_wr(wr_kind_e kind,
                                                 logic [DATA_W-1:0] cur,
                                                 logic [DATA_W-1:0] wd);
    case (kind)
      WR_SET:  return cur | wd;
      WR_CLR:  return cur & ~wd;
      WR_TOG:  return cur ^ wd;
      default: return wd;
    endcase
  endfunction
endpackage

// File: rtl/qmt_prescaler.sv
module qmt_prescaler #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] div_val,
  input  logic             run,
  input  logic             clr,
  output logic [CNT_W-1:0] psc,
  output logic             tick
);
  logic [CNT_W-1:0] psc_d;
  logic             psc_ce;

  always_comb begin
    tick   = run && !clr && (psc >= div_val);
    psc_ce = clr || run;
    if (clr || tick) psc_d = '0;
    else             psc_d = psc + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      psc <= '0;
    else if (psc_ce) psc <= psc_d;
  end

  a_r4_wrap_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (psc == '0));
  a_r3_prescale_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (psc == '0));
  a_r4_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !clr) |=> $stable(psc));
endmodule

// File: rtl/qmt_channel.sv
module qmt_channel #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             en,
  input  logic             clr,
  input  logic             down,
  input  logic [CNT_W-1:0] match_val,
  input  logic             zero_on_hit,
  output logic [CNT_W-1:0] cnt,
  output logic             hit
);
  logic             step;
  logic [CNT_W-1:0] nxt;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_ce;

  always_comb begin
    step   = tick && en && !clr;
    nxt    = down ? cnt - 1'b1 : cnt + 1'b1;
    hit    = step && (nxt == match_val);
    cnt_ce = clr || step;
    if (clr || (hit && zero_on_hit)) cnt_d = '0;
    else                             cnt_d = nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (cnt_ce) cnt <= cnt_d;
  end

  a_r3_held_zero: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt == '0));
  a_r5_step_dir: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && en && !clr && !hit) |=>
      (cnt == ($past(down) ? $past(cnt) - 1'b1 : $past(cnt) + 1'b1)));
  a_r6_reload_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && zero_on_hit) |=> (cnt == '0));
  a_r4_no_tick_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !clr) |=> $stable(cnt));
endmodule

// File: rtl/quad_match_timer.sv
module quad_match_timer #(
  parameter int NUM_CH = 4,
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 12
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [11:0] bus_addr,
  input  logic        bus_wr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        irq
);
  import qmt_pkg::*;

  localparam int IDX_W  = ADDR_W - 4;
  localparam int CTRL_W = 2 * NUM_CH;
  localparam int MCTL_W = 3 * NUM_CH;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe;
  logic       rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  wr_kind_e         kind;
  logic [IDX_W-1:0] idx;
  logic             unused_addr_lsb;
  assign kind = wr_kind_e'(bus_addr[3:2]);
  assign idx  = bus_addr[ADDR_W-1:4];
  assign unused_addr_lsb = ^bus_addr[1:0];

  // register state
  logic [NUM_CH-1:0] flag, flag_d;
  logic [NUM_CH-1:0] tcr_en, tcr_en_d;
  logic [NUM_CH-1:0] tcr_rst, tcr_rst_d;
  logic [NUM_CH-1:0] dir, dir_d;
  logic [CNT_W-1:0]  psv, psv_d;
  logic [MCTL_W-1:0] mctl, mctl_d;
  logic [CNT_W-1:0]  mr   [NUM_CH];
  logic [CNT_W-1:0]  mr_d [NUM_CH];
  logic [CNT_W-1:0]  cnt  [NUM_CH];
  logic [NUM_CH-1:0] hit, stop_hit;
  logic [CNT_W-1:0]  psc;
  logic              tick;
  logic [CTRL_W-1:0] ctrl_new;
  logic [DATA_W-1:0] dir_view, dir_new;
  logic              unused_dir_new;

  always_comb begin
    // flags: replace offset is write-one-to-clear; a match wins
    flag_d = flag;
    if (bus_wr && idx == IDX_W'(IDX_FLAG)) begin
      if (kind == WR_PLAIN) flag_d = flag & ~bus_wdata[NUM_CH-1:0];
      else flag_d = NUM_CH'(apply_wr(kind, DATA_W'(flag), bus_wdata));
    end
    flag_d = flag_d | hit;

    // control: stop-on-match overrides the bus
    ctrl_new  = CTRL_W'(apply_wr(kind, DATA_W'({tcr_rst, tcr_en}), bus_wdata));
    tcr_en_d  = tcr_en;
    tcr_rst_d = tcr_rst;
    if (bus_wr && idx == IDX_W'(IDX_CTRL)) begin
      tcr_en_d  = ctrl_new[NUM_CH-1:0];
      tcr_rst_d = ctrl_new[CTRL_W-1:NUM_CH];
    end
    tcr_en_d = tcr_en_d & ~stop_hit;

    // direction: one bit per channel at bit 4n
    dir_view = '0;
    for (int n = 0; n < NUM_CH; n++) dir_view[4*n] = dir[n];
    dir_new = apply_wr(kind, dir_view, bus_wdata);
    dir_d   = dir;
    if (bus_wr && idx == IDX_W'(IDX_DIR))
      for (int n = 0; n < NUM_CH; n++) dir_d[n] = dir_new[4*n];

    psv_d = psv;
    if (bus_wr && idx == IDX_W'(IDX_PSV))
      psv_d = CNT_W'(apply_wr(kind, DATA_W'(psv), bus_wdata));

    mctl_d = mctl;
    if (bus_wr && idx == IDX_W'(IDX_MCTL))
      mctl_d = MCTL_W'(apply_wr(kind, DATA_W'(mctl), bus_wdata));

    for (int n = 0; n < NUM_CH; n++) begin
      mr_d[n] = mr[n];
      if (bus_wr && idx == IDX_W'(IDX_MR0 + n))
        mr_d[n] = CNT_W'(apply_wr(kind, DATA_W'(mr[n]), bus_wdata));
    end
  end
  assign unused_dir_new = ^dir_new;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      flag    <= '0;
      tcr_en  <= '0;
      tcr_rst <= '0;
      dir     <= '0;
      psv     <= '0;
      mctl    <= '0;
      for (int n = 0; n < NUM_CH; n++) mr[n] <= '0;
    end else begin
      flag    <= flag_d;
      tcr_en  <= tcr_en_d;
      tcr_rst <= tcr_rst_d;
      dir     <= dir_d;
      psv     <= psv_d;
      mctl    <= mctl_d;
      for (int n = 0; n < NUM_CH; n++) mr[n] <= mr_d[n];
    end
  end

  qmt_prescaler #(.CNT_W(CNT_W)) i_prescaler (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .div_val (psv),
    .run     (|tcr_en),
    .clr     (|tcr_rst),
    .psc     (psc),
    .tick    (tick)
  );

  for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
    qmt_channel #(.CNT_W(CNT_W)) i_channel (
      .clk         (clk),
      .rst_n       (rst_sync_n),
      .tick        (tick),
      .en          (tcr_en[n]),
      .clr         (tcr_rst[n]),
      .down        (dir[n]),
      .match_val   (mr[n]),
      .zero_on_hit (mctl[3*n+1]),
      .cnt         (cnt[n]),
      .hit         (hit[n])
    );
    assign stop_hit[n] = hit[n] & mctl[3*n+2];

    a_r7_stop_clears_enable: assert property (@(posedge clk) disable iff (!rst_sync_n)
      stop_hit[n] |=> !tcr_en[n]);
    a_r8_match_sets_flag: assert property (@(posedge clk) disable iff (!rst_sync_n)
      hit[n] |=> flag[n]);
  end

  // R9: interrupt combines enabled flags
  always_comb begin
    irq = 1'b0;
    for (int n = 0; n < NUM_CH; n++) irq = irq | (flag[n] & mctl[3*n]);
  end

  // read mux
  always_comb begin
    bus_rdata = '0;
    if (idx == IDX_W'(IDX_FLAG)) bus_rdata = DATA_W'(flag);
    if (idx == IDX_W'(IDX_CTRL)) bus_rdata = DATA_W'({tcr_rst, tcr_en});
    if (idx == IDX_W'(IDX_DIR))  bus_rdata = dir_view;
    if (idx == IDX_W'(IDX_PSV))  bus_rdata = DATA_W'(psv);
    if (idx == IDX_W'(IDX_PSC))  bus_rdata = DATA_W'(psc);
    if (idx == IDX_W'(IDX_MCTL)) bus_rdata = DATA_W'(mctl);
    for (int n = 0; n < NUM_CH; n++) begin
      if (idx == IDX_W'(IDX_CNT0 + n)) bus_rdata = DATA_W'(cnt[n]);
      if (idx == IDX_W'(IDX_MR0 + n))  bus_rdata = DATA_W'(mr[n]);
    end
  end

  a_r9_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_sync_n)
    irq |-> (flag != '0));
endmodule

// File: tb/test_quad_match_timer.sv
module test_quad_match_timer;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [11:0] bus_addr;
  logic        bus_wr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        irq;

  int nvec = 0;
  int nbad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  quad_match_timer i_quad_match_timer (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  localparam logic [1:0] K_PLAIN = 2'd0, K_SET = 2'd1, K_CLR = 2'd2, K_TOG = 2'd3;
  localparam logic [7:0] X_FLAG = 8'h00, X_CTRL = 8'h01, X_DIR = 8'h02, X_CNT0 = 8'h03,
                         X_CNT1 = 8'h04, X_CNT2 = 8'h05, X_PSV = 8'h07, X_PSC = 8'h08,
                         X_MCTL = 8'h09, X_MR0 = 8'h0A, X_MR1 = 8'h0B, X_MR2 = 8'h0C;

  function automatic logic [11:0] adr(logic [7:0] x, logic [1:0] k);
    return {x, k, 2'b00};
  endfunction

  task automatic wr(logic [7:0] x, logic [1:0] k, logic [31:0] d);
    @(negedge clk);
    bus_addr = adr(x, k); bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk);
    #1 bus_wr = 1'b0;
  endtask

  task automatic peek(logic [7:0] x, logic [1:0] k, output logic [31:0] v);
    bus_addr = adr(x, k);
    #1 v = bus_rdata;
  endtask

  task automatic check(string req, string what, logic [31:0] got, logic [31:0] exp);
    nvec++;
    if (got !== exp) begin
      nbad++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic edges(int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic clean();
    wr(X_CTRL, K_PLAIN, 32'h0);
    wr(X_CTRL, K_PLAIN, 32'hF0);
    wr(X_CTRL, K_PLAIN, 32'h0);
    wr(X_MCTL, K_PLAIN, 32'h0);
    wr(X_PSV, K_PLAIN, 32'h0);
    wr(X_DIR, K_PLAIN, 32'h0);
    wr(X_FLAG, K_PLAIN, 32'hF);
  endtask

  task automatic t_reset_state();
    logic [31:0] v;
    peek(X_CTRL, K_PLAIN, v); check("R3", "control after reset", v, 0);
    peek(X_CNT0, K_PLAIN, v); check("R2", "counter0 after reset", v, 0);
    peek(X_FLAG, K_PLAIN, v); check("R8", "flags after reset", v, 0);
    check("R9", "irq after reset", {31'b0, irq}, 0);
  endtask

  task automatic t_alias();
    logic [31:0] v;
    wr(X_MR2, K_PLAIN, 32'h0000_0F0F);
    wr(X_MR2, K_TOG, 32'h0000_00FF);
    peek(X_MR2, K_TOG, v); check("R1", "toggle alias", v, 32'h0000_0FF0);
    wr(X_MR2, K_SET, 32'h0000_F000);
    peek(X_MR2, K_SET, v); check("R1", "set alias", v, 32'h0000_FFF0);
    wr(X_MR2, K_CLR, 32'h0000_0010);
    peek(X_MR2, K_PLAIN, v); check("R1", "clear alias", v, 32'h0000_FFE0);
  endtask

  task automatic t_readonly();
    logic [31:0] v;
    clean();
    wr(X_CNT2, K_PLAIN, 32'h1234_5678);
    peek(X_CNT2, K_PLAIN, v); check("R2", "counter write ignored", v, 0);
    wr(X_PSC, K_SET, 32'h0000_0003);
    peek(X_PSC, K_PLAIN, v); check("R2", "prescale counter write ignored", v, 0);
    peek(8'h20, K_PLAIN, v); check("R2", "unmapped reads zero", v, 0);
  endtask

  task automatic t_periodic();
    logic [31:0] v;
    clean();
    wr(X_MCTL, K_PLAIN, 32'h1);
    wr(X_MR0, K_PLAIN, 32'd3);
    wr(X_CTRL, K_SET, 32'h1);
    edges(6);
    peek(X_CNT0, K_PLAIN, v); check("R6", "periodic keeps counting", v, 32'd6);
    peek(X_FLAG, K_PLAIN, v); check("R6", "periodic match flag", v, 32'h1);
    check("R9", "irq on enabled flag", {31'b0, irq}, 1);
    wr(X_CTRL, K_CLR, 32'h1);
    wr(X_FLAG, K_PLAIN, 32'h1);
    peek(X_FLAG, K_PLAIN, v); check("R8", "write-one clears flag", v, 0);
    check("R9", "irq drops with flag", {31'b0, irq}, 0);
  endtask

  task automatic t_oneshot();
    logic [31:0] v;
    clean();
    wr(X_MCTL, K_PLAIN, 32'h7);
    wr(X_MR0, K_PLAIN, 32'd5);
    wr(X_CTRL, K_SET, 32'h1);
    edges(4);
    peek(X_CNT0, K_PLAIN, v); check("R4", "counts each clock with P=0", v, 32'd4);
    edges(6);
    peek(X_CNT0, K_PLAIN, v); check("R6", "one-shot reloads zero", v, 0);
    peek(X_CTRL, K_PLAIN, v); check("R7", "one-shot clears enable", v, 0);
    peek(X_FLAG, K_PLAIN, v); check("R6", "one-shot flag", v, 32'h1);
    check("R9", "one-shot irq", {31'b0, irq}, 1);
  endtask

  task automatic t_down_wrap();
    logic [31:0] v;
    clean();
    wr(X_DIR, K_PLAIN, 32'h0000_0010);
    wr(X_MR1, K_PLAIN, 32'hFFFF_FFF0);
    wr(X_MCTL, K_PLAIN, 32'h8);
    wr(X_CTRL, K_SET, 32'h2);
    edges(3);
    peek(X_CNT1, K_PLAIN, v); check("R5", "down count through zero", v, 32'hFFFF_FFFD);
    peek(X_FLAG, K_PLAIN, v); check("R5", "wrap sets no flag", v, 0);
    check("R5", "wrap raises no irq", {31'b0, irq}, 0);
    peek(X_DIR, K_PLAIN, v); check("R5", "direction readback", v, 32'h0000_0010);
  endtask

  task automatic t_prescale();
    logic [31:0] v;
    clean();
    wr(X_MR0, K_PLAIN, 32'hFFFF_0000);
    wr(X_PSV, K_PLAIN, 32'd2);
    peek(X_PSC, K_PLAIN, v); check("R4", "prescale idle holds", v, 0);
    wr(X_CTRL, K_SET, 32'h1);
    edges(9);
    peek(X_CNT0, K_PLAIN, v); check("R4", "divided count", v, 32'd3);
    peek(X_PSC, K_PLAIN, v); check("R4", "prescale wrapped", v, 0);
    edges(1);
    peek(X_PSC, K_PLAIN, v); check("R4", "prescale advances", v, 32'd1);
    peek(X_CNT0, K_PLAIN, v); check("R4", "no step between ticks", v, 32'd3);
  endtask

  task automatic t_channel_reset();
    logic [31:0] v;
    clean();
    wr(X_MR1, K_PLAIN, 32'hFFFF_0000);
    wr(X_CTRL, K_SET, 32'h2);
    edges(4);
    peek(X_CNT1, K_PLAIN, v); check("R3", "runs before reset", v, 32'd4);
    wr(X_CTRL, K_SET, 32'h20);
    edges(3);
    peek(X_CNT1, K_PLAIN, v); check("R3", "held at zero", v, 0);
    peek(X_PSC, K_PLAIN, v); check("R3", "prescale held at zero", v, 0);
    wr(X_CTRL, K_CLR, 32'h20);
    edges(5);
    peek(X_CNT1, K_PLAIN, v); check("R3", "resumes after release", v, 32'd5);
  endtask

  task automatic t_flag_alias();
    logic [31:0] v;
    clean();
    wr(X_FLAG, K_SET, 32'h4);
    peek(X_FLAG, K_PLAIN, v); check("R8", "set alias on flags", v, 32'h4);
    check("R9", "irq masked", {31'b0, irq}, 0);
    wr(X_MCTL, K_SET, 32'h40);
    check("R9", "irq unmasked", {31'b0, irq}, 1);
    wr(X_FLAG, K_TOG, 32'h5);
    peek(X_FLAG, K_PLAIN, v); check("R8", "toggle alias on flags", v, 32'h1);
    check("R9", "irq after toggle", {31'b0, irq}, 0);
    wr(X_FLAG, K_CLR, 32'h1);
    peek(X_FLAG, K_PLAIN, v); check("R8", "clear alias on flags", v, 0);
  endtask

  initial begin
    bus_addr = '0; bus_wr = 1'b0; bus_wdata = '0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    edges(4);
    t_reset_state();
    t_alias();
    t_readonly();
    t_periodic();
    t_oneshot();
    t_down_wrap();
    t_prescale();
    t_channel_reset();
    t_flag_alias();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nbad++;
      $display("FAIL watchdog: got hung run expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end
endmodule